// File: doc/BRIEF.md
# GPIO Port with Per-Pin Level Resolution

This block is a 16-pin general-purpose I/O port controlled through a 32-bit register interface. Software sets, per pin, whether the pin is an input or a general output, whether an output pushes both levels or only pulls low, and which pull resistor is applied. Output data can be written as a whole word, or changed one bit at a time through an atomic set/clear register and a clear-only register. Each pin also has an external drive input made of a level and an event strobe. An event re-attaches that pin's external source, and a single control input detaches all of them at once.

For every pin the port combines the mode, the output type, the pull setting, the stored output bit and the external drive into one resolved level. That level can be read back through the input data register and is also driven onto a per-pin line toward a system-configuration or interrupt consumer. When an output takes the pin, the port cuts off any external source that would fight it, and a per-pin flag shows which external sources are still attached. Mode codes other than general output behave as input.

Top module: `gpio_pin_port`

## Requirements
- R1: After a synchronous active-low reset, the mode, output-type, pull and output data registers read 0, every resolved level is 0 and every pin's external source is detached (pin_link = 0).
- R2: The mode register (offset 0x00) holds two bits per pin at bit 2*pin, where 01 selects general output and 00, 10 and 11 select input. The output-type register (0x04) holds one bit per pin (0 push-pull, 1 open-drain). The pull register (0x0C) holds two bits per pin at bit 2*pin (01 pull-up, 10 pull-down, 00 and 11 none). All three read back what was written.
- R3: An input pin whose external source is attached reads the external level. An external event on a pin stores its level and re-attaches the source (pin_link bit goes to 1) unless an output cuts it off in that cycle.
- R4: An input pin with no attached source reads 1 with pull-up, and 0 with pull-down or no pull.
- R5: A value written to the output data register (0x14) while a pin is an input is stored, readable at 0x14, and appears on the pin once the pin becomes a general output.
- R6: A push-pull output pin reads its output data bit whatever the external drive, and its external source is detached one clock after the configuration takes effect, or at once on a new external event.
- R7: An open-drain output pin whose output bit is 0 reads 0, and its external source is detached.
- R8: An open-drain output pin whose output bit is 1 releases the pin. An attached external low stays attached and the pin reads 0. An external high is detached and the pin then reads its pull level (1 for pull-up, else 0).
- R9: Writing the set/clear register (0x18) sets output bit n for each 1 in bit n (n < 16) and clears it for each 1 in bit n+16. Set wins when both are 1. Bits written 0 leave the output bit unchanged.
- R10: Writing 1 to bit n of the clear-only register (0x28) clears output bit n. Its upper 16 bits and its zero bits have no effect.
- R11: The input data register (0x10) reads the resolved pin levels and ignores writes. Offsets 0x18, 0x28 and unmapped offsets read 0.
- R12: pin_level equals the input data register bit for bit and reflects a register write or an external event one clock after it.
- R13: Asserting unplug_all detaches every pin's external source on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ext_event | input | 16 | Per-pin strobe: external source drives a level and re-attaches |
| ext_level | input | 16 | Per-pin external level, sampled when ext_event is 1 |
| unplug_all | input | 1 | Detach every pin's external source |
| pin_level | output | 16 | Resolved level of each pin |
| pin_link | output | 16 | 1 where the pin's external source is still attached |

## Verification
The bench targets the open-drain corner in which a released pin must keep an external low attached while detaching an external high. A design that treated open-drain like push-pull would read the output bit (1) instead of 0, and one that never detached would let the external high raise the pin. It also writes the set/clear register with both halves set for the same bit: a design that let clear win would leave the bit at 0. Other checks confirm that output data written while a pin is an input survives until the pin becomes an output, and that writes to the input data register or to the upper half of the clear-only register change nothing.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants for the GPIO port.
// Assumes a 6-bit byte offset and a 32-bit data path.
package gpio_port_pkg;
    localparam int REG_AW = 6;
    localparam logic [REG_AW-1:0] OFS_MODE  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_OTYPE = 6'h04;
    localparam logic [REG_AW-1:0] OFS_PULL  = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_IDATA = 6'h10;
    localparam logic [REG_AW-1:0] OFS_ODATA = 6'h14;
    localparam logic [REG_AW-1:0] OFS_SETCL = 6'h18;
    localparam logic [REG_AW-1:0] OFS_CLR   = 6'h28;
    localparam logic [1:0] MODE_OUT  = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b01;
    localparam logic [1:0] PULL_DOWN = 2'b10;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: configuration and output-data registers.
// Holds mode, output type, pull and output data; applies whole-word,
// set/clear (set wins) and clear-only writes. Assumes DW >= 2*NPINS.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       addr,
    input  logic [DW-1:0]           wdata,
    output logic [2*NPINS-1:0]      mode_q,
    output logic [NPINS-1:0]        otype_q,
    output logic [2*NPINS-1:0]      pull_q,
    output logic [NPINS-1:0]        odr_q
);
    logic [NPINS-1:0] set_bits;
    logic [NPINS-1:0] clr_bits;

    assign set_bits = wdata[NPINS-1:0];
    assign clr_bits = wdata[NPINS +: NPINS];

    // Register update on reset or on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            otype_q <= '0;
            pull_q  <= '0;
            odr_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_MODE:  mode_q  <= wdata[2*NPINS-1:0];
                OFS_OTYPE: otype_q <= wdata[NPINS-1:0];
                OFS_PULL:  pull_q  <= wdata[2*NPINS-1:0];
                OFS_ODATA: odr_q   <= wdata[NPINS-1:0];
                OFS_SETCL: odr_q   <= (odr_q & ~clr_bits) | set_bits;
                OFS_CLR:   odr_q   <= odr_q & ~set_bits;
                default:   ;
            endcase
        end
    end

    // R9: every bit named in the set half ends up 1
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SETCL) |=>
            ((odr_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

    // R10: every bit named in the clear-only write ends up 0
    assert_clear_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CLR) |=> ((odr_q & $past(wdata[NPINS-1:0])) == '0));

    // R11: a write to the input data offset leaves all registers unchanged
    assert_idata_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_IDATA) |=>
            ($stable(mode_q) && $stable(otype_q) && $stable(pull_q) && $stable(odr_q)));
endmodule

// File: rtl/gpio_ext_track.sv
// Module: per-pin external drive tracker.
// Stores each pin's external level and attach flag. An event attaches,
// unplug detaches all, and an output that takes the pin cuts the source
// off, judged on the configuration present at the same clock edge.
module gpio_ext_track #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] ev_valid,
    input  logic [NPINS-1:0] ev_level,
    input  logic             unplug,
    input  logic [NPINS-1:0] out_en,
    input  logic [NPINS-1:0] od,
    input  logic [NPINS-1:0] odr,
    output logic [NPINS-1:0] lvl_q,
    output logic [NPINS-1:0] conn_q
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic lvl_nx;
        logic conn_raw;
        logic cut;

        // Next external level and raw attach state before any cut-off.
        always_comb begin
            lvl_nx   = ev_valid[i] ? ev_level[i] : lvl_q[i];
            conn_raw = ev_valid[i] ? 1'b1 : (unplug ? 1'b0 : conn_q[i]);
            cut      = out_en[i] & (~od[i] | ~odr[i] | lvl_nx);
        end

        // Store level and attach flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i]  <= 1'b0;
                conn_q[i] <= 1'b0;
            end else begin
                lvl_q[i]  <= lvl_nx;
                conn_q[i] <= conn_raw & ~cut;
            end
        end

        // R6: a push-pull output never keeps an external source past one clock
        assert_pp_detach_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en[i] && !od[i]) |=> !conn_q[i]);

        // R7: an open-drain output driving low detaches its source
        assert_od_low_detach_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en[i] && od[i] && !odr[i]) |=> !conn_q[i]);
    end

    // R13: unplug with no event detaches every pin
    assert_unplug_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug && ev_valid == '0) |=> (conn_q == '0));
endmodule

// File: rtl/gpio_pin_resolve.sv
// Module: combinational per-pin level resolution.
// Push-pull output reads its data bit; open-drain low reads 0; a released
// open-drain or an input follows an attached external low or level, else
// the pull (up 1, down/none 0).
module gpio_pin_resolve #(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0] out_en,
    input  logic [NPINS-1:0] od,
    input  logic [NPINS-1:0] odr,
    input  logic [NPINS-1:0] pull_up,
    input  logic [NPINS-1:0] ext_lvl,
    input  logic [NPINS-1:0] ext_conn,
    output logic [NPINS-1:0] level
);
    for (genvar i = 0; i < NPINS; i++) begin : g_res
        // Resolve one pin.
        always_comb begin
            if (out_en[i] && !od[i])
                level[i] = odr[i];
            else if (out_en[i] && !odr[i])
                level[i] = 1'b0;
            else if (out_en[i])
                level[i] = (ext_conn[i] && !ext_lvl[i]) ? 1'b0 : pull_up[i];
            else
                level[i] = ext_conn[i] ? ext_lvl[i] : pull_up[i];
        end
    end
endmodule

// File: rtl/gpio_pin_port.sv
// Module: top of the GPIO port.
// Decodes per-pin fields, ties registers, external tracker and resolver
// together, and serves combinational register reads. Assumes NPINS = 16
// with a 32-bit data path.
module gpio_pin_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NPINS-1:0]  ext_event,
    input  logic [NPINS-1:0]  ext_level,
    input  logic              unplug_all,
    output logic [NPINS-1:0]  pin_level,
    output logic [NPINS-1:0]  pin_link
);
    localparam int PAD = DW - NPINS;

    logic [2*NPINS-1:0] mode_q, pull_q;
    logic [NPINS-1:0]   otype_q, odr_q;
    logic [NPINS-1:0]   out_en, pull_up, ext_lvl, ext_conn;

    gpio_cfg_regs #(.NPINS(NPINS), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .mode_q(mode_q), .otype_q(otype_q),
        .pull_q(pull_q), .odr_q(odr_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_dec
        assign out_en[i]  = (mode_q[2*i +: 2] == MODE_OUT);
        assign pull_up[i] = (pull_q[2*i +: 2] == PULL_UP);
    end

    gpio_ext_track #(.NPINS(NPINS)) u_ext (
        .clk(clk), .rst_n(rst_n), .ev_valid(ext_event), .ev_level(ext_level),
        .unplug(unplug_all), .out_en(out_en), .od(otype_q), .odr(odr_q),
        .lvl_q(ext_lvl), .conn_q(ext_conn)
    );

    gpio_pin_resolve #(.NPINS(NPINS)) u_res (
        .out_en(out_en), .od(otype_q), .odr(odr_q), .pull_up(pull_up),
        .ext_lvl(ext_lvl), .ext_conn(ext_conn), .level(pin_level)
    );

    assign pin_link = ext_conn;

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_MODE:  reg_rdata = mode_q;
            OFS_OTYPE: reg_rdata = {{PAD{1'b0}}, otype_q};
            OFS_PULL:  reg_rdata = pull_q;
            OFS_IDATA: reg_rdata = {{PAD{1'b0}}, pin_level};
            OFS_ODATA: reg_rdata = {{PAD{1'b0}}, odr_q};
            default:   reg_rdata = '0;
        endcase
    end

    // R7: open-drain output with data bit 0 reads low
    assert_od_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_en & otype_q & ~odr_q & pin_level) == '0));

    // R8: a released open-drain pin never reads high from an external source
    assert_od_no_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_en & otype_q & ~pull_up & pin_level) == '0));

    // R6: push-pull output reads its data bit
    assert_pp_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_level ^ odr_q) & out_en & ~otype_q) == '0));
endmodule

// File: tb/gpio_pin_port_test.sv
// Bench: directed scenarios for the GPIO port, one task per scenario.
module gpio_pin_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [15:0] ext_event = 0;
    logic [15:0] ext_level = 0;
    logic        unplug_all = 0;
    logic [15:0] pin_level;
    logic [15:0] pin_link;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_pin_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_event(ext_event),
        .ext_level(ext_level), .unplug_all(unplug_all),
        .pin_level(pin_level), .pin_link(pin_link)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ext(int pin, logic lvl);
        @(negedge clk);
        ext_event = 16'(1 << pin); ext_level = lvl ? 16'(1 << pin) : 16'h0;
        @(negedge clk);
        ext_event = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clean();
        wr(6'h00, 0); wr(6'h04, 0); wr(6'h0C, 0); wr(6'h14, 0);
        @(negedge clk); unplug_all = 1; @(negedge clk); unplug_all = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(6'h00, d); chk("R1 mode", d, 0);
        rd(6'h04, d); chk("R1 otype", d, 0);
        rd(6'h0C, d); chk("R1 pull", d, 0);
        rd(6'h14, d); chk("R1 odata", d, 0);
        rd(6'h10, d); chk("R1 idata", d, 0);
        chk("R1 link", {16'h0, pin_link}, 0);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        wr(6'h00, 32'h0000_2E40); rd(6'h00, d); chk("R2 mode readback", d, 32'h0000_2E40);
        wr(6'h04, 32'h0000_A5A5); rd(6'h04, d); chk("R2 otype readback", d, 32'h0000_A5A5);
        wr(6'h0C, 32'hC000_0003); rd(6'h0C, d); chk("R2 pull codes 11 none", d, 32'hC000_0003);
        rd(6'h10, d); chk("R2 pull 11 reads 0", d, 0);
        wr(6'h00, 32'h0000_0020); wr(6'h14, 32'h0000_0004);
        rd(6'h10, d); chk("R2 mode 10 acts as input", d, 0);
        clean();
    endtask

    task automatic t_input_ext();
        logic [31:0] d;
        ext(6, 1);
        rd(6'h10, d); chk("R3 ext high", d, 32'h40);
        chk("R3 link set", {16'h0, pin_link}, 32'h40);
        chk("R12 line matches", {16'h0, pin_level}, 32'h40);
        ext(6, 0);
        rd(6'h10, d); chk("R3 ext low", d, 0);
        @(negedge clk); unplug_all = 1; @(negedge clk); unplug_all = 0;
        chk("R13 unplug", {16'h0, pin_link}, 0);
    endtask

    task automatic t_pull();
        logic [31:0] d;
        wr(6'h0C, 32'h1 << 10);
        rd(6'h10, d); chk("R4 pull-up", d, 32'h20);
        chk("R12 one clock after write", {16'h0, pin_level}, 32'h20);
        wr(6'h0C, 32'h2 << 10);
        rd(6'h10, d); chk("R4 pull-down", d, 0);
        clean();
    endtask

    task automatic t_odr_stored();
        logic [31:0] d;
        wr(6'h14, 32'h20);
        rd(6'h10, d); chk("R5 stored not driven", d, 0);
        rd(6'h14, d); chk("R5 readback", d, 32'h20);
        wr(6'h00, 32'h1 << 10);
        rd(6'h10, d); chk("R5 appears on output", d, 32'h20);
        wr(6'h14, 0);
        rd(6'h10, d); chk("R5 output low", d, 0);
        clean();
    endtask

    task automatic t_pushpull();
        logic [31:0] d;
        ext(6, 1);
        wr(6'h00, 32'h1 << 12);
        rd(6'h10, d); chk("R6 ignores ext high", d, 0);
        tick();
        chk("R6 detached", {16'h0, pin_link}, 0);
        ext(6, 1);
        rd(6'h10, d); chk("R6 new ext ignored", d, 0);
        chk("R6 new ext detached", {16'h0, pin_link}, 0);
        clean();
        ext(9, 0);
        wr(6'h14, 32'h200); wr(6'h00, 32'h1 << 18);
        rd(6'h10, d); chk("R6 drives high over ext low", d, 32'h200);
        clean();
    endtask

    task automatic t_opendrain();
        logic [31:0] d;
        ext(4, 1);
        wr(6'h04, 32'h10); wr(6'h00, 32'h1 << 8);
        rd(6'h10, d); chk("R7 od low", d, 0);
        tick();
        chk("R7 detached", {16'h0, pin_link}, 0);
        clean();
        ext(11, 0);
        wr(6'h14, 32'h800); wr(6'h04, 32'h800); wr(6'h00, 32'h1 << 22);
        tick();
        chk("R8 ext low stays", {16'h0, pin_link}, 32'h800);
        rd(6'h10, d); chk("R8 reads low", d, 0);
        ext(11, 1);
        chk("R8 ext high detached", {16'h0, pin_link}, 0);
        rd(6'h10, d); chk("R8 ext high cannot raise", d, 0);
        wr(6'h0C, 32'h1 << 22);
        rd(6'h10, d); chk("R8 released reads pull-up", d, 32'h800);
        ext(11, 0);
        rd(6'h10, d); chk("R8 ext low wins over pull", d, 0);
        chk("R8 re-attached", {16'h0, pin_link}, 32'h800);
        clean();
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(6'h18, 32'h1 << 12); rd(6'h14, d); chk("R9 set", d, 32'h1000);
        wr(6'h18, 32'h1 << 28); rd(6'h14, d); chk("R9 clear", d, 0);
        wr(6'h18, (32'h1 << 12) | (32'h1 << 28)); rd(6'h14, d); chk("R9 set wins", d, 32'h1000);
        wr(6'h14, 32'h00F0); wr(6'h18, 32'h1 << 12);
        rd(6'h14, d); chk("R9 zeros no effect", d, 32'h10F0);
        rd(6'h18, d); chk("R11 setclr reads 0", d, 0);
    endtask

    task automatic t_clr();
        logic [31:0] d;
        wr(6'h28, 32'h1 << 12); rd(6'h14, d); chk("R10 clear", d, 32'h00F0);
        wr(6'h28, 32'hFFFF_0000); rd(6'h14, d); chk("R10 upper ignored", d, 32'h00F0);
        rd(6'h28, d); chk("R11 clr reads 0", d, 0);
        clean();
    endtask

    task automatic t_idata_ro();
        logic [31:0] d;
        wr(6'h0C, 32'h1 << 6);
        wr(6'h10, 32'h0);
        rd(6'h10, d); chk("R11 write ignored", d, 32'h8);
        rd(6'h0C, d); chk("R11 pull untouched", d, 32'h40);
        rd(6'h20, d); chk("R11 unmapped 0", d, 0);
        clean();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_input_ext();
        t_pull();
        t_odr_stored();
        t_pushpull();
        t_opendrain();
        t_setclr();
        t_clr();
        t_idata_ro();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule